// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This unit holds the interrupt bookkeeping and command status of a USB host controller. Single-cycle event pulses from the bus engine, frame timer and root hub are caught in sticky status bits. Software clears a bit by writing a one to it. A registered interrupt line rises when a pending bit is enabled and the master enable is on.

The command status side has a two-bit counter of scheduling overruns and a software reset request bit. Setting that bit starts a reset sequencer. The sequencer puts the controller in its suspended functional state, clears the event state and, after a fixed number of cycles, drops the request bit on its own. The root hub is not touched by this reset.

Software reaches every register through one register port. Each access carries an 8-bit command code. The read code of a register has bit 7 clear, and the write code is the same value with bit 7 set.

Top module: `hc_irq_status_unit`

## Requirements
- R1: Code 03h reads the status word: bit 0 overrun (SO), bit 2 frame start, bit 3 resume, bit 4 fatal error, bit 5 frame-counter wrap, bit 6 hub change. Bits 1 and 31:7 always read 0, and an event pulse on `evt_i[1]` sets nothing. With `reg_cmd_valid` low, `reg_rdata` is 0.
- R2: A pulse on `evt_i[k]` (k in 0, 2..6) sets status bit k at the next clock edge, and the bit stays set.
- R3: A write with code 83h clears each status bit whose data bit is 1 and leaves the others unchanged. No write can set a status bit.
- R4: If an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: `irq_o` is a register. It is 1 one cycle after a clock edge at which some status bit and its enable bit are both 1 and the master enable is 1. Otherwise it is 0.
- R6: Code 84h writes and code 04h reads the enable word: bits 6:0 enable the status bit at the same position (bit 1 always reads 0), and bit 31 is the master enable.
- R7: Code 02h reads the command status word, with the overrun count in bits 17:16. The count starts at 0, adds one on every `evt_i[0]` pulse whether or not SO is already set, and wraps from 3 to 0.
- R8: A write with code 82h and data bit 0 set starts a reset. From the next edge on: bit 0 of the 02h word reads 1, `fs_o` is 11b, and the status bits and overrun count are 0. The enable word keeps its value.
- R9: The reset bit reads 1 for exactly `RST_CYCLES` cycles, then clears itself. At the default setting this is well under 10 ms at 250 MHz.
- R10: While a reset runs, events are ignored, functional-state writes are ignored and another start has no effect. Writing 82h with bit 0 clear never starts a reset.
- R11: Code 81h writes and code 01h reads the functional state in bits 7:6, also driven on `fs_o`: 00b reset, 01b resume, 10b operational, 11b suspended. After a finished software reset the state stays 11b.
- R12: After `rst_n` is released, all four registers read 0, and `irq_o` and `fs_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_cmd_valid | input | 1 | Register access this cycle |
| reg_cmd | input | 8 | Command code; bit 7 set selects a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current read code |
| evt_i | input | 7 | Event pulses, aligned with the status bit positions |
| irq_o | output | 1 | Registered interrupt request |
| fs_o | output | 2 | Functional state of the controller |

## Verification
The bench drives an event and a clearing write on the same bit in the same cycle. A design that let the clear win would lose the event and read 0. It pulses the overrun event while SO is already set and carries the count past 3. A counter that only counted rising edges of SO, or that saturated, would read 1 or 3 where the bench expects 0 and then 1. It measures the reset bit cycle by cycle, then sends events, state writes and a second start during a reset. An off-by-one sequencer would give a length of `RST_CYCLES`±1, a leaky flush would leave status set, and a sequencer that restarts would stretch the pulse. It also checks the interrupt one cycle after the enabling edge and not before, with the master enable off, and with an enable on a bit that is not pending.

// File: rtl/hcis_pkg.sv
package hcis_pkg;

    localparam int STS_W   = 7;
    localparam int SOC_W   = 2;
    localparam int DATA_W  = 32;
    localparam int CMD_W   = 8;

    // implemented status positions; bit 1 is reserved
    localparam logic [STS_W-1:0] STS_VALID = 7'b111_1101;

    localparam int SO_BIT   = 0;
    localparam int HCR_BIT  = 0;
    localparam int SOC_LSB  = 16;
    localparam int FS_LSB   = 6;
    localparam int MIE_BIT  = 31;

    localparam logic [CMD_W-1:0] CMD_CTRL_RD  = 8'h01;
    localparam logic [CMD_W-1:0] CMD_CTRL_WR  = 8'h81;
    localparam logic [CMD_W-1:0] CMD_CMDST_RD = 8'h02;
    localparam logic [CMD_W-1:0] CMD_CMDST_WR = 8'h82;
    localparam logic [CMD_W-1:0] CMD_STS_RD   = 8'h03;
    localparam logic [CMD_W-1:0] CMD_STS_WR   = 8'h83;
    localparam logic [CMD_W-1:0] CMD_IEN_RD   = 8'h04;
    localparam logic [CMD_W-1:0] CMD_IEN_WR   = 8'h84;

    typedef enum logic [1:0] {
        FS_RESET   = 2'b00,
        FS_RESUME  = 2'b01,
        FS_OPER    = 2'b10,
        FS_SUSPEND = 2'b11
    } fstate_e;

endpackage

// File: rtl/hcis_evt_latch.sv
module hcis_evt_latch
    import hcis_pkg::*;
#(
    parameter int NSTS = STS_W,
    parameter int NSOC = SOC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTS-1:0] evt_i,
    input  logic [NSTS-1:0] clr_i,
    input  logic            flush_i,
    output logic [NSTS-1:0] sts_o,
    output logic [NSOC-1:0] soc_o
);

    typedef struct packed {
        logic [NSTS-1:0] sts;
        logic [NSOC-1:0] soc;
    } latch_t;

    latch_t          st_d, st_q;
    logic [NSTS-1:0] hit;

    // per-bit set/clear; an event outranks a clear on the same bit
    for (genvar b = 0; b < NSTS; b++) begin : g_bit
        assign hit[b] = evt_i[b] & STS_VALID[b];
    end

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.sts = '0;
            st_d.soc = '0;
        end else begin
            st_d.sts = (st_q.sts & ~clr_i) | hit;
            if (hit[SO_BIT]) begin
                st_d.soc = st_q.soc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;
    assign soc_o = st_q.soc;

endmodule

// File: rtl/hcis_rst_seq.sv
module hcis_rst_seq
    import hcis_pkg::*;
#(
    parameter int RST_CYCLES = 64,
    localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       fs_wr_i,
    input  logic [1:0] fs_wdata_i,
    output logic       busy_o,
    output logic [1:0] fs_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        fstate_e          fs;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(RST_CYCLES - 1);
            st_d.fs   = FS_SUSPEND;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (fs_wr_i) begin
            st_d.fs = fstate_e'(fs_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, fs: FS_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign fs_o   = st_q.fs;

endmodule

// File: rtl/hcis_irq_gate.sv
module hcis_irq_gate
    import hcis_pkg::*;
#(
    parameter int NSTS = STS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NSTS-1:0] en_wdata_i,
    input  logic            mie_wdata_i,
    input  logic [NSTS-1:0] sts_i,
    output logic [NSTS-1:0] en_o,
    output logic            mie_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [NSTS-1:0] en;
        logic            mie;
        logic            irq;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.en  = en_wdata_i & STS_VALID;
            st_d.mie = mie_wdata_i;
        end
        st_d.irq = st_q.mie & (|(sts_i & st_q.en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign mie_o = st_q.mie;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/hc_irq_status_unit.sv
module hc_irq_status_unit
    import hcis_pkg::*;
#(
    parameter int RST_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_cmd_valid,
    input  logic [CMD_W-1:0]  reg_cmd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [STS_W-1:0]  evt_i,
    output logic              irq_o,
    output logic [1:0]        fs_o
);

    logic             wr_ctrl, wr_cmdst, wr_sts, wr_ien;
    logic             start, busy, flush, mie_q;
    logic [STS_W-1:0] sts_q, en_q, clr_mask;
    logic [SOC_W-1:0] soc_q;

    assign wr_ctrl  = reg_cmd_valid && (reg_cmd == CMD_CTRL_WR);
    assign wr_cmdst = reg_cmd_valid && (reg_cmd == CMD_CMDST_WR);
    assign wr_sts   = reg_cmd_valid && (reg_cmd == CMD_STS_WR);
    assign wr_ien   = reg_cmd_valid && (reg_cmd == CMD_IEN_WR);

    assign start    = wr_cmdst && reg_wdata[HCR_BIT] && !busy;
    assign flush    = start || busy;
    assign clr_mask = wr_sts ? reg_wdata[STS_W-1:0] : '0;

    hcis_evt_latch #(.NSTS(STS_W), .NSOC(SOC_W)) i_evt_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_i   (clr_mask),
        .flush_i (flush),
        .sts_o   (sts_q),
        .soc_o   (soc_q)
    );

    hcis_rst_seq #(.RST_CYCLES(RST_CYCLES)) i_rst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .fs_wr_i    (wr_ctrl),
        .fs_wdata_i (reg_wdata[FS_LSB+1:FS_LSB]),
        .busy_o     (busy),
        .fs_o       (fs_o)
    );

    hcis_irq_gate #(.NSTS(STS_W)) i_irq_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_ien),
        .en_wdata_i  (reg_wdata[STS_W-1:0]),
        .mie_wdata_i (reg_wdata[MIE_BIT]),
        .sts_i       (sts_q),
        .en_o        (en_q),
        .mie_o       (mie_q),
        .irq_o       (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_cmd_valid) begin
            unique case (reg_cmd)
                CMD_CTRL_RD:  reg_rdata[FS_LSB+1:FS_LSB] = fs_o;
                CMD_CMDST_RD: begin
                    reg_rdata[SOC_LSB+SOC_W-1:SOC_LSB] = soc_q;
                    reg_rdata[HCR_BIT]                 = busy;
                end
                CMD_STS_RD:   reg_rdata[STS_W-1:0] = sts_q;
                CMD_IEN_RD:   begin
                    reg_rdata[STS_W-1:0] = en_q;
                    reg_rdata[MIE_BIT]   = mie_q;
                end
                default:      reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/hcis_checker.sv
module hcis_checker
    import hcis_pkg::*;
#(
    parameter int RST_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_cmd_valid,
    input logic [CMD_W-1:0]  reg_cmd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [STS_W-1:0]  evt_i,
    input logic [STS_W-1:0]  sts_q,
    input logic [SOC_W-1:0]  soc_q,
    input logic              flush,
    input logic              busy,
    input logic              mie_q,
    input logic              irq_o,
    input logic [1:0]        fs_o
);

    logic [31:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cmd_valid && reg_cmd == CMD_STS_RD) |-> (reg_rdata[31:7] == '0 && reg_rdata[1] == 1'b0)); // R1

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~$past(sts_q) & ~$past(evt_i)) == '0)); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flush) |-> ((sts_q & $past(evt_i & STS_VALID)) == $past(evt_i & STS_VALID))); // R4

    AST_IRQ_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mie_q) |-> !irq_o); // R5

    AST_SOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(flush) && $past(evt_i[SO_BIT])) |-> (soc_q == $past(soc_q) + 1'b1)); // R7

    AST_RESET_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (fs_o == 2'b11 && sts_q == '0 && soc_q == '0)); // R8

    AST_RESET_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RST_CYCLES); // R9

endmodule

bind hc_irq_status_unit hcis_checker #(.RST_CYCLES(RST_CYCLES)) i_hcis_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_cmd_valid (reg_cmd_valid),
    .reg_cmd       (reg_cmd),
    .reg_rdata     (reg_rdata),
    .evt_i         (evt_i),
    .sts_q         (sts_q),
    .soc_q         (soc_q),
    .flush         (flush),
    .busy          (busy),
    .mie_q         (mie_q),
    .irq_o         (irq_o),
    .fs_o          (fs_o)
);

// File: tb/test_hc_irq_status_unit.sv
module test_hc_irq_status_unit;

    localparam int RST_CYCLES = 64;
    localparam int MAX_10MS   = 2_500_000; // 10 ms at 4 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_cmd_valid = 1'b0;
    logic [7:0]  reg_cmd = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  evt_i = '0;
    logic        irq_o;
    logic [1:0]  fs_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hc_irq_status_unit #(.RST_CYCLES(RST_CYCLES)) i_hc_irq_status_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_cmd_valid (reg_cmd_valid),
        .reg_cmd       (reg_cmd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .evt_i         (evt_i),
        .irq_o         (irq_o),
        .fs_o          (fs_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one clock of stimulus, starting and ending at a falling edge
    task automatic drive(input logic v, input logic [7:0] c, input logic [31:0] d, input logic [6:0] e);
        reg_cmd_valid = v;
        reg_cmd       = c;
        reg_wdata     = d;
        evt_i         = e;
        @(negedge clk);
        reg_cmd_valid = 1'b0;
        reg_cmd       = '0;
        reg_wdata     = '0;
        evt_i         = '0;
    endtask

    task automatic wr(input logic [7:0] c, input logic [31:0] d);
        drive(1'b1, c, d, 7'h00);
    endtask

    task automatic pulse(input logic [6:0] e);
        drive(1'b0, 8'h00, 32'h0, e);
    endtask

    task automatic rd(input logic [7:0] c, output logic [31:0] d);
        reg_cmd_valid = 1'b1;
        reg_cmd       = c;
        #1;
        d             = reg_rdata;
        reg_cmd_valid = 1'b0;
        reg_cmd       = '0;
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        rd(8'h01, d); chk("R12 ctrl", d, 32'h0);
        rd(8'h02, d); chk("R12 cmdst", d, 32'h0);
        rd(8'h03, d); chk("R12 status", d, 32'h0);
        rd(8'h04, d); chk("R12 enable", d, 32'h0);
        chk("R12 irq", {31'h0, irq_o}, 32'h0);
        chk("R12 fs", {30'h0, fs_o}, 32'h0);
        reg_cmd_valid = 1'b0; reg_cmd = 8'h03; #1;
        chk("R1 idle rdata", reg_rdata, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_event_latch();
        logic [31:0] d;
        pulse(7'b000_0100);
        rd(8'h03, d); chk("R2 frame start", d, 32'h04);
        @(negedge clk);
        rd(8'h03, d); chk("R2 sticky", d, 32'h04);
        pulse(7'b000_0010);
        rd(8'h03, d); chk("R1 reserved event", d, 32'h04);
        pulse(7'b100_1000);
        rd(8'h03, d); chk("R2 two events", d, 32'h4C);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h83, 32'h0);
        rd(8'h03, d); chk("R3 write zero", d, 32'h4C);
        wr(8'h83, 32'h04);
        rd(8'h03, d); chk("R3 clear one", d, 32'h48);
        wr(8'h83, 32'hFFFF_FFFF);
        rd(8'h03, d); chk("R3 clear all", d, 32'h0);
        wr(8'h83, 32'h7D);
        rd(8'h03, d); chk("R3 no set", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        drive(1'b1, 8'h83, 32'h10, 7'h10);
        rd(8'h03, d); chk("R4 event wins", d, 32'h10);
        drive(1'b1, 8'h83, 32'h10, 7'h04);
        rd(8'h03, d); chk("R4 other bit clears", d, 32'h04);
        wr(8'h83, 32'h04);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h84, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R6 enable readback", d, 32'h8000_007D);
        wr(8'h84, 32'h0000_0004);
        rd(8'h04, d); chk("R6 enable no mie", d, 32'h0000_0004);
        pulse(7'h04);
        @(negedge clk);
        chk("R5 no master", {31'h0, irq_o}, 32'h0);
        wr(8'h84, 32'h8000_0004);
        chk("R5 registered lag", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R5 asserted", {31'h0, irq_o}, 32'h1);
        wr(8'h83, 32'h04);
        @(negedge clk);
        chk("R5 drop on clear", {31'h0, irq_o}, 32'h0);
        wr(8'h84, 32'h8000_0010);
        pulse(7'h04);
        @(negedge clk);
        chk("R5 other enable", {31'h0, irq_o}, 32'h0);
        wr(8'h83, 32'h04);
        wr(8'h84, 32'h8000_0004);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        pulse(7'h01);
        rd(8'h02, d); chk("R7 count 1", d, 32'h0001_0000);
        rd(8'h03, d); chk("R7 SO set", d, 32'h01);
        pulse(7'h01);
        pulse(7'h01);
        rd(8'h02, d); chk("R7 count 3 with SO set", d, 32'h0003_0000);
        pulse(7'h01);
        rd(8'h02, d); chk("R7 wrap", d, 32'h0);
        pulse(7'h01);
        rd(8'h02, d); chk("R7 after wrap", d, 32'h0001_0000);
    endtask

    task automatic t_state();
        logic [31:0] d;
        wr(8'h81, 32'h80);
        rd(8'h01, d); chk("R11 operational", d, 32'h80);
        chk("R11 fs_o", {30'h0, fs_o}, 32'h2);
        wr(8'h81, 32'h40);
        rd(8'h01, d); chk("R11 resume", d, 32'h40);
        wr(8'h81, 32'h80);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        int cnt;
        pulse(7'h04);
        @(negedge clk);
        chk("R5 before reset", {31'h0, irq_o}, 32'h1);
        wr(8'h82, 32'h0);
        rd(8'h02, d); chk("R10 write zero no start", d, 32'h0001_0000);
        wr(8'h82, 32'h1);
        rd(8'h03, d); chk("R8 status cleared", d, 32'h0);
        rd(8'h04, d); chk("R8 enable kept", d, 32'h8000_0004);
        chk("R8 suspend", {30'h0, fs_o}, 32'h3);
        cnt = 0;
        for (int i = 0; i < RST_CYCLES + 10; i++) begin
            rd(8'h02, d);
            if (i == 0) chk("R8 busy and count cleared", d, 32'h1);
            if (d[0]) cnt++;
            else break;
            @(negedge clk);
        end
        chk("R9 length", cnt, RST_CYCLES);
        chk("R9 within 10 ms", {31'h0, (cnt <= MAX_10MS)}, 32'h1);
        rd(8'h02, d); chk("R9 self clear", d, 32'h0);
        chk("R11 stays suspend", {30'h0, fs_o}, 32'h3);
        chk("R8 irq low", {31'h0, irq_o}, 32'h0);

        wr(8'h82, 32'h1);
        pulse(7'h7D);
        wr(8'h81, 32'h80);
        wr(8'h82, 32'h1);
        cnt = 3;
        for (int i = 0; i < RST_CYCLES + 10; i++) begin
            rd(8'h02, d);
            if (!d[0]) break;
            cnt++;
            @(negedge clk);
        end
        chk("R10 no restart", cnt, RST_CYCLES);
        rd(8'h03, d); chk("R10 events ignored", d, 32'h0);
        rd(8'h02, d); chk("R10 count untouched", d, 32'h0);
        chk("R10 state write ignored", {30'h0, fs_o}, 32'h3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_event_latch();
        t_w1c();
        t_collision();
        t_irq();
        t_overrun();
        t_state();
        t_soft_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule